// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter Chain

This block holds wall-clock time and calendar date as seven packed-BCD registers: seconds, minutes, hours, weekday, day of month, month and two-digit year. Each cycle in which the one-pulse-per-second `tick` input is high, seconds advance. Carries pass along the chain, so minutes, hours, weekday, date, month and year roll over at their natural limits. The date limit follows the current month, and February has a leap day in years that are multiples of four.

The hours register has two format choices. Bit 7 selects 12-hour mode (1) or 24-hour mode (0). In 12-hour mode, bit 5 is the afternoon flag, and the hour runs 01 through 12. A host loads or inspects the registers through a byte-wide register port that occupies seven consecutive addresses starting at `BASE_ADDR` (0x20 by default). The tick source and the host bus adapter sit outside this block.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the registers hold seconds 0x00, minutes 0x00, hours 0x00 (24-hour mode), weekday 0x01, date 0x01, month 0x01 and year 0x00.
- R2: Seconds and minutes count in BCD from 00 to 59. The wrap of seconds advances minutes, and the wrap of both advances hours.
- R3: In 24-hour mode (hours bit 7 = 0), hours count 00 to 23 in BCD. The step from 23 back to 00 advances the weekday and the date.
- R4: In 12-hour mode (hours bit 7 = 1, bit 5 = PM, bits 4:0 = BCD hour), 11 steps to 12 with PM inverted, and 12 steps to 01 with PM kept. Only the step from 11 PM to 12 AM advances the weekday and the date.
- R5: The weekday counts 1 to 7 (Sunday = 1) and wraps from 7 to 1.
- R6: The date wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in every other month except February. Each wrap advances the month.
- R7: In February, the date wraps after day 29 when the decimal value of the BCD year is a multiple of 4, and after day 28 otherwise.
- R8: The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00.
- R9: A write with `wr_en` high loads the register at `wr_addr`. The offsets from `BASE_ADDR` are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month and 6 year. Unused bits are stored as 0: the keep masks are 0x7F, 0x7F, 0xBF, 0x07, 0x3F, 0x1F and 0xFF. Writes to any other address change nothing.
- R10: A write to a register in the same cycle as a tick takes priority for that register. The other registers advance from the carries of the values they held before that cycle.
- R11: With `tick` and `wr_en` both low, no register changes.
- R12: `rd_data` presents the register at `rd_addr` combinationally, using the same offsets as R9, and reads 0x00 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours with mode and PM flags |
| wday_o | output | 8 | Weekday 1..7 |
| mday_o | output | 8 | Date, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year, BCD |

## Verification
The bench goes after the carry boundaries, each of which a careless design gets wrong in a visible way:
- **12-hour boundaries.** Around 11 and 12, a design that inverts PM at the wrong step or advances the day at noon would show the wrong half-day or a doubled date.
- **Month lengths.** The ends of 30-day and 31-day months and the BCD month steps 09 to 10 and 12 to 01 are exercised. A binary increment would produce 0x0A.
- **Leap-year test.** February is checked in years 24, 23, 00 and 10. Year 10 catches a design that tests the raw BCD byte for divisibility instead of the decimal value.
- **Write and tick together.** A same-cycle write and tick, writes outside the address window, and the masking of unused bits are also checked. A flawed design would lose the write, corrupt a neighbouring register, or keep stray bits.

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [7:0]        sec_o,
  output logic [7:0]        min_o,
  output logic [7:0]        hour_o,
  output logic [7:0]        wday_o,
  output logic [7:0]        mday_o,
  output logic [7:0]        month_o,
  output logic [7:0]        year_o
);

  localparam logic [ADDR_W-1:0] A_SEC = BASE_ADDR;
  localparam logic [ADDR_W-1:0] A_MIN = BASE_ADDR + 1;
  localparam logic [ADDR_W-1:0] A_HR  = BASE_ADDR + 2;
  localparam logic [ADDR_W-1:0] A_WD  = BASE_ADDR + 3;
  localparam logic [ADDR_W-1:0] A_MD  = BASE_ADDR + 4;
  localparam logic [ADDR_W-1:0] A_MON = BASE_ADDR + 5;
  localparam logic [ADDR_W-1:0] A_YR  = BASE_ADDR + 6;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic [7:0] sec_q, min_q, hr_q, wd_q, md_q, mon_q, yr_q;

  assign sec_o   = sec_q;
  assign min_o   = min_q;
  assign hour_o  = hr_q;
  assign wday_o  = wd_q;
  assign mday_o  = md_q;
  assign month_o = mon_q;
  assign year_o  = yr_q;

  // write decode
  wire w_sec = wr_en && (wr_addr == A_SEC);
  wire w_min = wr_en && (wr_addr == A_MIN);
  wire w_hr  = wr_en && (wr_addr == A_HR);
  wire w_wd  = wr_en && (wr_addr == A_WD);
  wire w_md  = wr_en && (wr_addr == A_MD);
  wire w_mon = wr_en && (wr_addr == A_MON);
  wire w_yr  = wr_en && (wr_addr == A_YR);

  // hour step
  logic [7:0] hr_nx, inc_tmp;
  logic       day_adv;
  always_comb begin
    inc_tmp = 8'h00;
    day_adv = 1'b0;
    hr_nx   = hr_q;
    if (!hr_q[7]) begin
      day_adv = (hr_q[5:0] == 6'h23);
      inc_tmp = bcd_inc({2'b00, hr_q[5:0]});
      hr_nx   = day_adv ? 8'h00 : {2'b00, inc_tmp[5:0]};
    end else begin
      inc_tmp = bcd_inc({3'b000, hr_q[4:0]});
      if (hr_q[4:0] == 5'h11) begin
        hr_nx   = {1'b1, 1'b0, ~hr_q[5], 5'h12};
        day_adv = hr_q[5];
      end else if (hr_q[4:0] == 5'h12) begin
        hr_nx = {1'b1, 1'b0, hr_q[5], 5'h01};
      end else begin
        hr_nx = {1'b1, 1'b0, hr_q[5], inc_tmp[4:0]};
      end
    end
  end

  // month length; (10*t+u) mod 4 equals (2*t+u) mod 4
  logic [5:0] leap_sum;
  logic [7:0] last_day;
  assign leap_sum = {1'b0, yr_q[7:4], 1'b0} + {2'b00, yr_q[3:0]};
  always_comb begin
    case (mon_q)
      8'h02:                      last_day = (leap_sum[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  // carry chain from pre-update values
  wire c_min = tick  && (sec_q == 8'h59);
  wire c_hr  = c_min && (min_q == 8'h59);
  wire c_day = c_hr  && day_adv;
  wire c_mon = c_day && (md_q == last_day);
  wire c_yr  = c_mon && (mon_q == 8'h12);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q <= 8'h00;
      min_q <= 8'h00;
      hr_q  <= 8'h00;
      wd_q  <= 8'h01;
      md_q  <= 8'h01;
      mon_q <= 8'h01;
      yr_q  <= 8'h00;
    end else begin
      if (w_sec)      sec_q <= wr_data & 8'h7F;
      else if (tick)  sec_q <= (sec_q == 8'h59) ? 8'h00 : bcd_inc(sec_q);

      if (w_min)      min_q <= wr_data & 8'h7F;
      else if (c_min) min_q <= (min_q == 8'h59) ? 8'h00 : bcd_inc(min_q);

      if (w_hr)       hr_q <= wr_data & 8'hBF;
      else if (c_hr)  hr_q <= hr_nx;

      if (w_wd)       wd_q <= wr_data & 8'h07;
      else if (c_day) wd_q <= (wd_q == 8'h07) ? 8'h01 : wd_q + 8'h01;

      if (w_md)       md_q <= wr_data & 8'h3F;
      else if (c_day) md_q <= (md_q == last_day) ? 8'h01 : bcd_inc(md_q);

      if (w_mon)      mon_q <= wr_data & 8'h1F;
      else if (c_mon) mon_q <= (mon_q == 8'h12) ? 8'h01 : bcd_inc(mon_q);

      if (w_yr)       yr_q <= wr_data;
      else if (c_yr)  yr_q <= (yr_q == 8'h99) ? 8'h00 : bcd_inc(yr_q);
    end
  end

  always_comb begin
    if      (rd_addr == A_SEC) rd_data = sec_q;
    else if (rd_addr == A_MIN) rd_data = min_q;
    else if (rd_addr == A_HR)  rd_data = hr_q;
    else if (rd_addr == A_WD)  rd_data = wd_q;
    else if (rd_addr == A_MD)  rd_data = md_q;
    else if (rd_addr == A_MON) rd_data = mon_q;
    else if (rd_addr == A_YR)  rd_data = yr_q;
    else                       rd_data = 8'h00;
  end

endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
module rtc_bcd_calendar_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic [7:0]        sec_o,
  input logic [7:0]        min_o,
  input logic [7:0]        hour_o,
  input logic [7:0]        wday_o,
  input logic [7:0]        mday_o,
  input logic [7:0]        month_o,
  input logic [7:0]        year_o
);

  wire top_of_hour = tick && !wr_en && sec_o == 8'h59 && min_o == 8'h59;

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable({sec_o, min_o, hour_o, wday_o, mday_o, month_o, year_o}));

  a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && sec_o == 8'h59) |=> (sec_o == 8'h00));

  a_r9_sec_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == BASE_ADDR) |=> (sec_o == ($past(wr_data) & 8'h7F)));

  a_r3_midnight: assert property (@(posedge clk) disable iff (!rst_n)
    (top_of_hour && hour_o == 8'h23) |=> (hour_o == 8'h00 && mday_o != $past(mday_o)));

  a_r4_noon_to_one: assert property (@(posedge clk) disable iff (!rst_n)
    (top_of_hour && hour_o[7] && hour_o[4:0] == 5'h12)
      |=> (hour_o[4:0] == 5'h01 && hour_o[5] == $past(hour_o[5]) && $stable(mday_o)));

  a_r5_week_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (top_of_hour && hour_o == 8'h23 && wday_o == 8'h07) |=> (wday_o == 8'h01));

endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
  .wday_o(wday_o), .mday_o(mday_o), .month_o(month_o), .year_o(year_o)
);

// File: tb/rtc_bcd_calendar_tb.sv
module rtc_bcd_calendar_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_addr = 8'h00;
  logic [7:0] rd_data, sec_o, min_o, hour_o, wday_o, mday_o, month_o, year_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  rtc_bcd_calendar u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
    .mday_o(mday_o), .month_o(month_o), .year_o(year_o)
  );

  // {tag, preload sec..year, expected after one tick}
  localparam logic [143:0] VEC [0:19] = '{
    {"R2  ", 56'h12_34_05_03_15_06_24, 56'h13_34_05_03_15_06_24},
    {"R2  ", 56'h59_34_05_03_15_06_24, 56'h00_35_05_03_15_06_24},
    {"R2  ", 56'h59_59_09_03_15_06_24, 56'h00_00_10_03_15_06_24},
    {"R3  ", 56'h59_59_23_03_15_06_24, 56'h00_00_00_04_16_06_24},
    {"R4  ", 56'h59_59_91_03_15_06_24, 56'h00_00_B2_03_15_06_24},
    {"R4  ", 56'h59_59_B2_03_15_06_24, 56'h00_00_A1_03_15_06_24},
    {"R4  ", 56'h59_59_B1_03_15_06_24, 56'h00_00_92_04_16_06_24},
    {"R4  ", 56'h59_59_92_03_15_06_24, 56'h00_00_81_03_15_06_24},
    {"R5  ", 56'h59_59_23_07_15_06_24, 56'h00_00_00_01_16_06_24},
    {"R6  ", 56'h59_59_23_02_30_04_24, 56'h00_00_00_03_01_05_24},
    {"R6  ", 56'h59_59_23_02_30_05_24, 56'h00_00_00_03_31_05_24},
    {"R6  ", 56'h59_59_23_02_31_10_24, 56'h00_00_00_03_01_11_24},
    {"R6  ", 56'h59_59_23_02_30_09_24, 56'h00_00_00_03_01_10_24},
    {"R7  ", 56'h59_59_23_02_28_02_24, 56'h00_00_00_03_29_02_24},
    {"R7  ", 56'h59_59_23_02_29_02_24, 56'h00_00_00_03_01_03_24},
    {"R7  ", 56'h59_59_23_02_28_02_23, 56'h00_00_00_03_01_03_23},
    {"R7  ", 56'h59_59_23_02_28_02_00, 56'h00_00_00_03_29_02_00},
    {"R7  ", 56'h59_59_23_02_28_02_10, 56'h00_00_00_03_01_03_10},
    {"R8  ", 56'h59_59_23_02_31_12_99, 56'h00_00_00_03_01_01_00},
    {"R8  ", 56'h59_59_23_02_31_12_09, 56'h00_00_00_03_01_01_10}
  };

  function automatic logic [55:0] regs();
    return {sec_o, min_o, hour_o, wday_o, mday_o, month_o, year_o};
  endfunction

  task automatic check(input string req, input logic [55:0] act, input logic [55:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input logic [55:0] v);
    for (int i = 0; i < 7; i++) wr(8'h20 + 8'(i), v[55 - 8*i -: 8]);
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [55:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", regs(), 56'h00_00_00_01_01_01_00);

    for (int i = 0; i < 20; i++) begin
      load(VEC[i][111:56]);
      pulse();
      check($sformatf("%s", VEC[i][143:112]), regs(), VEC[i][55:0]);
    end

    // R11: no tick, no write -> no change
    snap = regs();
    repeat (5) @(negedge clk);
    check("R11", regs(), snap);

    // R9: unused bits dropped on write
    wr(8'h20, 8'hFF); wr(8'h22, 8'hFF); wr(8'h23, 8'hFF); wr(8'h24, 8'hFF); wr(8'h25, 8'hFF);
    check("R9", regs(), {8'h7F, snap[47:40], 8'hBF, 8'h07, 8'h3F, 8'h1F, snap[7:0]});

    // R9: writes outside the window ignored
    load(56'h10_20_08_02_05_03_30);
    wr(8'h27, 8'h55); wr(8'h1F, 8'h55); wr(8'h00, 8'h55);
    check("R9", regs(), 56'h10_20_08_02_05_03_30);

    // R12: read port
    rd_addr = 8'h22; #1;
    check("R12", {48'h0, rd_data}, {48'h0, 8'h08});
    rd_addr = 8'h26; #1;
    check("R12", {48'h0, rd_data}, {48'h0, 8'h30});
    rd_addr = 8'h27; #1;
    check("R12", {48'h0, rd_data}, 56'h0);

    // R10: write wins over tick on the same cycle, others carry
    load(56'h59_59_23_02_05_03_30);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 8'h20; wr_data = 8'h30;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    check("R10", regs(), 56'h30_00_00_03_06_03_30);

    // R1: reset again from a non-reset state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1", regs(), 56'h00_00_00_01_01_01_00);

    finish_run();
  end
endmodule